// File: doc/BRIEF.md
# Lane Transmit Staging Buffer

This block sits between a framing-layer MAC and the transmit PCS of one serial lane. The MAC hands it one word per clock: a payload, a flag that tells a control word from a data word, and a valid strobe. The flag is the compressed form of the 2-bit sync header. A word is stored only in a cycle where the block's global ready output and the word's valid strobe are both high. The ready-to-accept rule has zero latency.

Stored words wait in a small FIFO. The block drops its per-lane backpressure output when the FIFO occupancy reaches a programmable almost-full level. This leaves room for writes that are already in flight. The PCS side pulls words through a ready/valid port with a registered output stage. On that port the 2-bit sync header is rebuilt from the stored flag.

A write that arrives while the FIFO is full is dropped. It also sets a sticky error flag.

Top module: `ltb_lane_tx_buf`

## Requirements
- R1: `in_word` is laid out as follows: bits PAY_W-1:0 are the payload, bit PAY_W is the flag (0 = data word, 1 = control word), and bit PAY_W+1 is the valid strobe.
- R2: Each word on the read port carries `out_hdr` = 2'b01 when its stored flag was 0, and 2'b10 when its stored flag was 1.
- R3: A word is stored only at a rising edge where `rdy` and the valid bit are both 1. Any other word is discarded and never appears on the read port.
- R4: `rdy` is 0 after any rising edge at which `rst` is 1. It becomes 1 after the first rising edge at which `rst` is 0. A valid word held during the first cycle with `rdy` at 1 is accepted exactly once.
- R5: `lane_bp_n` is 0 exactly when the FIFO holds at least AF_LEVEL words, and 1 otherwise. The word held in the output register is not counted.
- R6: A write presented while the FIFO holds DEPTH words is discarded and sets `ovf_err`. `ovf_err` then stays 1 until reset.
- R7: Words leave in the order they were accepted. When the FIFO and the output register are both empty, a word accepted at edge k makes `out_valid` 1 after edge k+1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the signals `out_valid`, `out_payload` and `out_hdr` hold their values. A transfer happens at a rising edge where both `out_valid` and `out_ready` are 1.
- R9: A synchronous `rst` empties the FIFO and the output register and clears `ovf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | PAY_W+2 | Payload, control flag and valid strobe from the MAC |
| rdy | output | 1 | Global ready; the block is out of reset |
| lane_bp_n | output | 1 | High while the lane can take more words |
| ovf_err | output | 1 | Sticky: a write hit a full FIFO |
| out_valid | output | 1 | Read port holds a word |
| out_ready | input | 1 | PCS side takes the word |
| out_payload | output | PAY_W | Payload of the presented word |
| out_hdr | output | 2 | Rebuilt sync header |

## Verification
The bench targets the following corner cases:
- **Reset exit.** A valid word is held across the cycle in which `rdy` rises. A design that ignored `rdy` would store this word twice, and a design with ready latency would lose it.
- **Fill sweep.** The FIFO is filled one word at a time past full, and `lane_bp_n` is checked at every level. An off-by-one threshold, or a count that includes the output register, flips backpressure one word early or late. Wrapped pointers on the extra write would corrupt the drained order or leak the dropped word.
- **Streams.** Invalid words carrying junk payloads are interleaved with real traffic under several read-stall patterns. This catches header inversion, lost stalls and reordering.
- **Mid-traffic reset.** A reset is applied while words are buffered. Any stale word or a surviving error flag shows up on the read port.

// File: rtl/ltb_pkg.sv
package ltb_pkg;

  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  // Restore the two-bit sync header from the one-bit control flag.
  function automatic logic [1:0] hdr_from_flag(input logic is_ctrl);
    return is_ctrl ? HDR_CTRL : HDR_DATA;
  endfunction

endpackage

// File: rtl/ltb_ready_gen.sv
module ltb_ready_gen (
  input  logic clk,
  input  logic rst,
  output logic rdy
);

  always_ff @(posedge clk) begin
    if (rst) rdy <= 1'b0;
    else     rdy <= 1'b1;
  end

endmodule

// File: rtl/ltb_fifo.sv
module ltb_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 65
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic                     pop,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata,
  output logic [$clog2(DEPTH):0]   occ,
  output logic                     full,
  output logic                     empty
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0]  wptr, rptr;
  logic [W-1:0] mem [DEPTH];
  logic         do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= wdata;
  end

  assign occ   = wptr - rptr;
  assign full  = (occ == FULL_CNT);
  assign empty = (occ == '0);
  assign rdata = mem[rptr[AW-1:0]];

endmodule

// File: rtl/ltb_out_stage.sv
module ltb_out_stage #(
  parameter int PAY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_avail,
  input  logic [PAY_W:0]   src_word,
  output logic             take,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_payload,
  output logic [1:0]       out_hdr
);

  assign take = src_avail && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_payload <= src_word[PAY_W-1:0];
      out_hdr     <= ltb_pkg::hdr_from_flag(src_word[PAY_W]);
    end
  end

endmodule

// File: rtl/ltb_lane_tx_buf.sv
module ltb_lane_tx_buf #(
  parameter int PAY_W    = 64,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = DEPTH - 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PAY_W+1:0] in_word,
  output logic             rdy,
  output logic             lane_bp_n,
  output logic             ovf_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_payload,
  output logic [1:0]       out_hdr
);

  localparam int AW      = $clog2(DEPTH);
  localparam int VLD_BIT = PAY_W + 1;
  localparam logic [AW:0] AF_CNT = (AW+1)'(AF_LEVEL);

  logic           in_valid;
  logic           wr_fire;
  logic           ovf_hit;
  logic           fifo_full, fifo_empty;
  logic           rd_take;
  logic [AW:0]    occ;
  logic [PAY_W:0] fifo_q;

  assign in_valid = in_word[VLD_BIT];
  assign wr_fire  = rdy && in_valid;
  assign ovf_hit  = wr_fire && fifo_full;

  ltb_ready_gen u_rdy (
    .clk (clk),
    .rst (rst),
    .rdy (rdy)
  );

  ltb_fifo #(.DEPTH(DEPTH), .W(PAY_W+1)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_fire),
    .pop   (rd_take),
    .wdata (in_word[PAY_W:0]),
    .rdata (fifo_q),
    .occ   (occ),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  ltb_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .src_avail   (!fifo_empty),
    .src_word    (fifo_q),
    .take        (rd_take),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (out_payload),
    .out_hdr     (out_hdr)
  );

  assign lane_bp_n = !(occ >= AF_CNT);

  always_ff @(posedge clk) begin
    if (rst)          ovf_err <= 1'b0;
    else if (ovf_hit) ovf_err <= 1'b1;
  end

endmodule

// File: rtl/ltb_chk.sv
module ltb_chk #(
  parameter int PAY_W = 64,
  parameter int OCC_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             rdy,
  input logic             wr_fire,
  input logic             fifo_full,
  input logic [OCC_W-1:0] occ,
  input logic             lane_bp_n,
  input logic             ovf_err,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PAY_W-1:0] out_payload,
  input logic [1:0]       out_hdr
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R4: ready is low after an edge that saw reset
  always_ff @(posedge clk) begin
    if (rst_d) a_r4_rdy_low_after_reset: assert (!rdy);
  end

  a_r2_hdr_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hdr == 2'b01 || out_hdr == 2'b10));

  a_r3_no_fill_unready: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> (occ <= $past(occ)));

  a_r5_empty_no_bp: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> lane_bp_n);

  a_r6_ovf_on_full_write: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && fifo_full) |=> ovf_err);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload) && $stable(out_hdr)));

endmodule

bind ltb_lane_tx_buf ltb_chk #(.PAY_W(PAY_W), .OCC_W(AW+1)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rdy         (rdy),
  .wr_fire     (wr_fire),
  .fifo_full   (fifo_full),
  .occ         (occ),
  .lane_bp_n   (lane_bp_n),
  .ovf_err     (ovf_err),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_payload (out_payload),
  .out_hdr     (out_hdr)
);

// File: tb/test_ltb_lane_tx_buf.sv
module test_ltb_lane_tx_buf;

  localparam int PAY_W    = 64;
  localparam int DEPTH    = 16;
  localparam int AF_LEVEL = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic [PAY_W+1:0] in_word;
  logic             rdy, lane_bp_n, ovf_err, out_valid, out_ready;
  logic [PAY_W-1:0] out_payload;
  logic [1:0]       out_hdr;

  always #10 clk = ~clk;

  ltb_lane_tx_buf #(.PAY_W(PAY_W), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) i_ltb_lane_tx_buf (
    .clk(clk), .rst(rst), .in_word(in_word), .rdy(rdy), .lane_bp_n(lane_bp_n),
    .ovf_err(ovf_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_payload(out_payload), .out_hdr(out_hdr)
  );

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [PAY_W:0] sb [0:511];
  int sb_w, sb_r;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hdr(input logic f);
    return f ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [63:0] pat(input int i);
    return (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic bit in_pick(input int m, input int c);
    return (m == 0) ? 1'b1 : ((c % 3) != 1);
  endfunction

  function automatic bit out_pick(input int m, input int c);
    if (m == 0) return 1'b1;
    if (m == 1) return (c % 7) < 3;
    return c >= 40;
  endfunction

  task automatic idle(input int c);
    in_word = {1'b0, 1'(c & 1), ~pat(c)};  // R3: junk with valid low
  endtask

  task automatic stream(input int nwords, input int in_mode, input int out_mode);
    int sent = 0;
    int cyc = 0;
    sb_w = 0;
    sb_r = 0;
    while (sb_r < nwords && cyc < 5000) begin
      bit ordy;
      logic f;
      logic [63:0] p;
      @(negedge clk);
      ordy = out_pick(out_mode, cyc);
      if (out_valid && ordy) begin
        if (sb_r >= sb_w) chk(1'b0, "R3 unexpected word", out_payload, 64'd0);
        else begin
          chk(out_payload == sb[sb_r][63:0], "R7 order/payload", out_payload, sb[sb_r][63:0]);
          chk(out_hdr == exp_hdr(sb[sb_r][PAY_W]), "R2 header", 64'(out_hdr), 64'(exp_hdr(sb[sb_r][PAY_W])));
          sb_r++;
        end
      end
      out_ready = ordy;
      if (sent < nwords && lane_bp_n && in_pick(in_mode, cyc)) begin
        p = pat(1000 * (out_mode + 1) + sent);
        f = p[5] ^ 1'(sent & 1);
        in_word = {1'b1, f, p};
        sb[sb_w] = {f, p};
        sb_w++;
        sent++;
      end else idle(cyc);
      cyc++;
    end
    chk(sb_r == nwords, "R7 all words delivered", 64'(sb_r), 64'(nwords));
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle(k);
      chk(out_valid == 1'b0, "R3 invalid words not stored", 64'(out_valid), 64'd0);
    end
  endtask

  initial begin
    rst = 1'b1;
    out_ready = 1'b0;
    in_word = {1'b1, 1'b0, pat(999)};
    repeat (3) @(negedge clk);
    chk(rdy == 1'b0, "R4 rdy low in reset", 64'(rdy), 64'd0);
    chk(out_valid == 1'b0, "R9 out_valid cleared", 64'(out_valid), 64'd0);
    chk(lane_bp_n == 1'b1, "R5 no backpressure empty", 64'(lane_bp_n), 64'd1);
    chk(ovf_err == 1'b0, "R9 ovf cleared", 64'(ovf_err), 64'd0);

    // Reset exit: word held across the rdy rise (R4, R1, R7)
    rst = 1'b0;
    in_word = {1'b1, 1'b0, pat(0)};
    @(negedge clk);
    chk(rdy == 1'b1, "R4 rdy rises", 64'(rdy), 64'd1);
    @(negedge clk);
    idle(0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7 latency", 64'(out_valid), 64'd1);
    chk(out_payload == pat(0), "R1 payload bits", out_payload, pat(0));
    chk(out_hdr == 2'b01, "R2 data header", 64'(out_hdr), 64'h1);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 accepted exactly once", 64'(out_valid), 64'd0);

    // Control word (R1 flag bit, R2)
    in_word = {1'b1, 1'b1, pat(1)};
    @(negedge clk);
    idle(1);
    @(negedge clk);
    chk(out_valid && out_payload == pat(1), "R1 control payload", out_payload, pat(1));
    chk(out_hdr == 2'b10, "R2 control header", 64'(out_hdr), 64'h2);
    @(negedge clk);

    // Streams with stalls (R2, R3, R7, R8)
    stream(40, 0, 0);
    stream(40, 1, 1);
    stream(30, 0, 2);

    // Fill sweep (R5, R6)
    out_ready = 1'b0;
    for (int n = 1; n <= DEPTH + 2; n++) begin
      int occ_e;
      occ_e = (n - 1 > DEPTH) ? DEPTH : n - 1;
      @(negedge clk);
      in_word = {1'b1, 1'(n & 1), pat(100 + n)};
      @(negedge clk);
      idle(n);
      @(negedge clk);
      chk(lane_bp_n == (occ_e < AF_LEVEL), "R5 backpressure level", 64'(lane_bp_n), 64'(occ_e < AF_LEVEL));
      chk(ovf_err == (n > DEPTH + 1), "R6 overflow flag", 64'(ovf_err), 64'(n > DEPTH + 1));
    end
    for (int k = 1; k <= DEPTH + 1; k++) begin
      @(negedge clk);
      chk(out_valid && out_payload == pat(100 + k), "R7 drain order", out_payload, pat(100 + k));
      chk(out_hdr == exp_hdr(1'(k & 1)), "R2 drain header", 64'(out_hdr), 64'(exp_hdr(1'(k & 1))));
      out_ready = 1'b1;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 dropped word absent", 64'(out_valid), 64'd0);
    chk(ovf_err == 1'b1, "R6 ovf sticky", 64'(ovf_err), 64'd1);

    // Reset with buffered words (R9)
    out_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      in_word = {1'b1, 1'b0, pat(300 + k)};
      @(negedge clk);
    end
    idle(7);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b0, "R4 rdy low after reset", 64'(rdy), 64'd0);
    chk(out_valid == 1'b0, "R9 output emptied", 64'(out_valid), 64'd0);
    chk(ovf_err == 1'b0, "R9 ovf cleared", 64'(ovf_err), 64'd0);
    chk(lane_bp_n == 1'b1, "R9 fifo emptied", 64'(lane_bp_n), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    in_word = {1'b1, 1'b1, pat(400)};
    @(negedge clk);
    idle(8);
    @(negedge clk);
    chk(out_valid && out_payload == pat(400), "R9 first word after reset", out_payload, pat(400));
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 no stale words", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule